// File: doc/BRIEF.md
# Power-Up Lifecycle Sequencer

This block walks a programmable device through its start-up life: a hold after power comes good, a configuration phase in which data is being loaded, a fixed initialization phase, and finally user mode, where the dual-purpose pins are handed to the user design. The power-good level, the configuration-complete flag and the configuration-error flag come from other logic and are taken here as plain inputs. Bitstream decoding, CRC checking and supply monitoring are not modelled.

The hold after power-good has three selectable lengths: none at all (instant start), a short nominal delay of 6 ms, and a long nominal delay of 100 ms. Both nominal delays are turned into clock counts from a clock-frequency parameter, which a simulation build sets low. The status and done signals behave like open-drain pins: the block only ever pulls them low, and it reads each back through a separate input so that other logic can hold either line low. Error recovery is either automatic or waits for an external active-low restart request, which is honoured only after it has been held for a minimum number of cycles.

Top module: `cfg_lifecycle_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until power-good is seen, `stat_drive_low` and `done_drive_low` are 1 and `user_en` is 0.
- R2: With `por_mode` = 2'b00 (instant start) the status pull-down is released in the same cycle in which `pwr_good` is high, with no delay count.
- R3: With `por_mode` = 2'b01 the status pull-down is released after `pwr_good` has been sampled high on CLK_HZ*6/1000 consecutive clock edges.
- R4: With `por_mode` = 2'b10 or 2'b11 the status pull-down is released after CLK_HZ*100/1000 consecutive edges with `pwr_good` high.
- R5: If `pwr_good` falls during the hold, the delay count starts again from zero.
- R6: In configuration, a sampled `cfg_loaded` starts initialization and releases the done pull-down; `user_en` rises INIT_CYC edges later, provided the done line reads back high throughout.
- R7: An external pull-down on the line read back by `stat_in` keeps the block in the hold phase, so `cfg_loaded` is ignored; an external pull-down on the line read back by `done_in` stalls the initialization count for every edge it is held.
- R8: A sampled `cfg_err` in configuration with `auto_restart` = 1 leaves the block in configuration with status released, and a later `cfg_loaded` completes normally.
- R9: A sampled `cfg_err` in configuration with `auto_restart` = 0 pulls status low and holds there; `cfg_loaded` is then ignored until a restart.
- R10: `cfg_req_n` held low for TCFG_CYC consecutive edges returns the block to the hold phase from any state, clearing `user_en` and pulling done low; a shorter low pulse has no effect.
- R11: While the restart request stays low the block remains in the hold phase with status pulled low; the delay starts counting only after release.
- R12: Same-cycle priority: a qualifying restart beats `cfg_err`, and `cfg_err` beats `cfg_loaded`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (internal oscillator) |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | All monitored supplies are in range |
| por_mode | input | 2 | Hold length: 00 none, 01 short, 10/11 long |
| cfg_req_n | input | 1 | Active-low configuration restart request |
| cfg_loaded | input | 1 | Configuration data fully loaded |
| cfg_err | input | 1 | Configuration error detected |
| auto_restart | input | 1 | 1: recover from an error without outside help |
| stat_in | input | 1 | Read-back of the wired status line |
| done_in | input | 1 | Read-back of the wired done line |
| stat_drive_low | output | 1 | Pull-down enable for the status line |
| done_drive_low | output | 1 | Pull-down enable for the done line |
| user_en | output | 1 | User mode; dual-purpose pins belong to the user |

## Verification
The collision of interest is a restart request that reaches its minimum length on the same edge that the configuration logic reports an error or completion, and the collision of an error with a completion flag. The bench counts the restart request's low edges so that its qualifying edge carries `cfg_err`, then releases the request and judges the outcome from the status line: the hold phase releases status at once in instant mode, whereas the error wait would keep it low. Error and completion together are judged by whether status falls (no auto-restart) or stays released with `user_en` never rising (auto-restart).

// File: rtl/lcs_pkg.sv
// Package lcs_pkg
// Shared state and mode encodings for the lifecycle sequencer.
package lcs_pkg;

    typedef enum logic [2:0] {
        ST_HOLD = 3'd0,   // power-on hold, status pulled low
        ST_LOAD = 3'd1,   // configuration data loading
        ST_INIT = 3'd2,   // initialization count
        ST_USER = 3'd3,   // user mode
        ST_FAIL = 3'd4    // error, waiting for restart
    } life_st_t;

    localparam logic [1:0] MODE_INSTANT = 2'b00;
    localparam logic [1:0] MODE_SHORT   = 2'b01;

endpackage

// File: rtl/lcs_hold_timer.sv
// Module lcs_hold_timer
// Counts consecutive cycles of good power while the sequencer is in the hold
// phase and reports when the selected delay has elapsed.
// Assumes: SHORT_CYC <= LONG_CYC; the count clears whenever power drops,
// a restart request is held, or the sequencer is outside the hold phase.
module lcs_hold_timer #(
    parameter int SHORT_CYC = 60,
    parameter int LONG_CYC  = 1000,
    localparam int CW       = $clog2(LONG_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       pwr_good,
    input  logic       hold_req,
    input  logic [1:0] mode,
    output logic       elapsed
);
    import lcs_pkg::*;

    logic [CW-1:0] cnt;
    logic [CW-1:0] target;

    // Select the delay length from the mode field.
    always_comb begin
        case (mode)
            MODE_INSTANT: target = '0;
            MODE_SHORT:   target = CW'(SHORT_CYC);
            default:      target = CW'(LONG_CYC);
        endcase
    end

    // Count good-power cycles, saturating at the target.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !pwr_good || hold_req) begin
            cnt <= '0;
        end else if (cnt < target) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign elapsed = run && pwr_good && !hold_req && (cnt >= target);

    // R3
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed && mode != MODE_INSTANT) |-> $past(run && pwr_good));

endmodule

// File: rtl/lcs_req_filter.sv
// Module lcs_req_filter
// Qualifies the active-low restart request: it fires a one-cycle pulse on the
// edge where the request has been sampled low for TCFG_CYC consecutive edges.
// Assumes: TCFG_CYC >= 2; one pulse per continuous low period.
module lcs_req_filter #(
    parameter int TCFG_CYC = 8,
    localparam int RW      = $clog2(TCFG_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic hit
);
    logic [RW-1:0] low_cnt;

    // Count consecutive low samples, saturating at the minimum length.
    always_ff @(posedge clk) begin
        if (!rst_n || req_n) begin
            low_cnt <= '0;
        end else if (low_cnt != RW'(TCFG_CYC)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign hit = !req_n && (low_cnt == RW'(TCFG_CYC - 1));

    // R10
    req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(!req_n));

endmodule

// File: rtl/lcs_init_timer.sv
// Module lcs_init_timer
// Counts initialization cycles while the done line reads back high and flags
// the last one.
// Assumes: INIT_CYC >= 1; the count clears outside initialization.
module lcs_init_timer #(
    parameter int INIT_CYC = 64,
    localparam int IW      = $clog2(INIT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic finish
);
    logic [IW-1:0] cnt;

    // Advance on every cycle the done line is free.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign finish = run && tick && (cnt == IW'(INIT_CYC - 1));

endmodule

// File: rtl/cfg_lifecycle_seq.sv
// Module cfg_lifecycle_seq
// Top of the power-up lifecycle sequencer: hold, load, init, user, with an
// error wait. Restart requests take priority over everything, then errors,
// then load completion.
// Assumes: inputs are synchronous to clk; status and done are open-drain lines
// whose wired levels come back on stat_in and done_in.
module cfg_lifecycle_seq #(
    parameter int CLK_HZ   = 10000,
    parameter int SHORT_MS = 6,
    parameter int LONG_MS  = 100,
    parameter int TCFG_CYC = 8,
    parameter int INIT_CYC = 64,
    localparam int SHORT_CYC = CLK_HZ * SHORT_MS / 1000,
    localparam int LONG_CYC  = CLK_HZ * LONG_MS / 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic [1:0] por_mode,
    input  logic       cfg_req_n,
    input  logic       cfg_loaded,
    input  logic       cfg_err,
    input  logic       auto_restart,
    input  logic       stat_in,
    input  logic       done_in,
    output logic       stat_drive_low,
    output logic       done_drive_low,
    output logic       user_en
);
    import lcs_pkg::*;

    life_st_t st, st_nxt;
    logic     hold_done;
    logic     restart_hit;
    logic     init_done;

    lcs_hold_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st == ST_HOLD),
        .pwr_good (pwr_good),
        .hold_req (!cfg_req_n),
        .mode     (por_mode),
        .elapsed  (hold_done)
    );

    lcs_req_filter #(
        .TCFG_CYC (TCFG_CYC)
    ) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (cfg_req_n),
        .hit   (restart_hit)
    );

    lcs_init_timer #(
        .INIT_CYC (INIT_CYC)
    ) u_init (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st == ST_INIT),
        .tick   (done_in),
        .finish (init_done)
    );

    // Choose the next lifecycle state by priority.
    always_comb begin
        st_nxt = st;
        if (restart_hit) begin
            st_nxt = ST_HOLD;
        end else begin
            case (st)
                ST_HOLD: if (hold_done && stat_in) st_nxt = ST_LOAD;
                ST_LOAD: begin
                    if (cfg_err)         st_nxt = auto_restart ? ST_LOAD : ST_FAIL;
                    else if (cfg_loaded) st_nxt = ST_INIT;
                end
                ST_INIT: if (init_done) st_nxt = ST_USER;
                default: st_nxt = st;
            endcase
        end
    end

    // Hold the lifecycle state.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HOLD;
        else        st <= st_nxt;
    end

    assign stat_drive_low = ((st == ST_HOLD) && !hold_done) || (st == ST_FAIL);
    assign done_drive_low = (st == ST_HOLD) || (st == ST_LOAD) || (st == ST_FAIL);
    assign user_en        = (st == ST_USER);

    // R1
    user_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_en |-> (!stat_drive_low && !done_drive_low));

    // R6
    user_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_en) |-> $past(done_in));

    // R8
    auto_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD && cfg_err && auto_restart && !restart_hit)
        |=> (!stat_drive_low && !user_en && done_drive_low));

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD && cfg_err && !auto_restart && !restart_hit) |=> stat_drive_low);

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_hit |=> (!user_en && done_drive_low));

endmodule

// File: tb/cfg_lifecycle_seq_test.sv
module cfg_lifecycle_seq_test;
    localparam int CLK_HZ   = 10000;
    localparam int TCFG     = 8;
    localparam int INIT     = 64;
    localparam int SHORT_D  = CLK_HZ * 6 / 1000;
    localparam int LONG_D   = CLK_HZ * 100 / 1000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, pwr_good, cfg_req_n, cfg_loaded, cfg_err, auto_restart;
    logic [1:0] por_mode;
    logic       stat_ext, done_ext;
    logic       stat_drive_low, done_drive_low, user_en;
    logic       stat_in, done_in;

    assign stat_in = !(stat_drive_low || stat_ext);
    assign done_in = !(done_drive_low || done_ext);

    cfg_lifecycle_seq #(
        .CLK_HZ   (CLK_HZ),
        .TCFG_CYC (TCFG),
        .INIT_CYC (INIT)
    ) uut (
        .clk (clk), .rst_n (rst_n), .pwr_good (pwr_good), .por_mode (por_mode),
        .cfg_req_n (cfg_req_n), .cfg_loaded (cfg_loaded), .cfg_err (cfg_err),
        .auto_restart (auto_restart), .stat_in (stat_in), .done_in (done_in),
        .stat_drive_low (stat_drive_low), .done_drive_low (done_drive_low),
        .user_en (user_en)
    );

    int errs = 0;
    int checks = 0;

    function automatic int exp_hold(input logic [1:0] m);
        if (m == 2'b00) return 0;
        if (m == 2'b01) return SHORT_D;
        return LONG_D;
    endfunction

    function automatic int exp_init(input int stall);
        return INIT + 1 + stall;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pwr_good = 1'b0; por_mode = 2'b00; cfg_req_n = 1'b1;
        cfg_loaded = 1'b0; cfg_err = 1'b0; auto_restart = 1'b0;
        stat_ext = 1'b0; done_ext = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    // Raise power good and count negedges until status is released.
    task automatic power_up(input logic [1:0] m, output int n);
        por_mode = m;
        pwr_good = 1'b1;
        n = 0;
        #1;
        while (stat_drive_low && n < 5000) begin
            @(negedge clk);
            n++;
        end
        cyc(1);
    endtask

    // Pulse cfg_loaded, stall the done line, count negedges until user mode.
    task automatic load_measure(input int stall, output int n);
        cfg_loaded = 1'b1;
        done_ext = (stall > 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (user_en) break;
            if (n == 1) cfg_loaded = 1'b0;
            if (n == stall + 1) done_ext = 1'b0;
        end while (n < 2000);
        cfg_loaded = 1'b0;
        done_ext = 1'b0;
    endtask

    // Hold the restart request for len edges; report first negedge without user mode.
    task automatic restart(input int len, output int drop);
        cfg_req_n = 1'b0;
        drop = 0;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (!user_en && drop == 0) drop = i;
        end
        cfg_req_n = 1'b1;
        cyc(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n;
        int drop;
        int unsigned seed;
        seed = $urandom(32'd4021);

        // R1: reset state
        rst_n = 1'b0; pwr_good = 1'b0; por_mode = 2'b00; cfg_req_n = 1'b1;
        cfg_loaded = 1'b0; cfg_err = 1'b0; auto_restart = 1'b0;
        stat_ext = 1'b0; done_ext = 1'b0;
        cyc(3);
        chk(stat_drive_low && done_drive_low && !user_en, "R1 in reset",
            {stat_drive_low, done_drive_low, user_en}, 3'b110);
        rst_n = 1'b1;
        cyc(5);
        chk(stat_drive_low && done_drive_low && !user_en, "R1 no power",
            {stat_drive_low, done_drive_low, user_en}, 3'b110);

        // R2: instant start
        power_up(2'b00, n);
        chk(n == exp_hold(2'b00), "R2 instant delay", n, exp_hold(2'b00));
        chk(done_drive_low && !user_en, "R2 in load", done_drive_low, 1);

        // R6: load then init
        load_measure(0, n);
        chk(n == exp_init(0), "R6 init length", n, exp_init(0));
        chk(!done_drive_low && !stat_drive_low, "R6 lines released", done_drive_low, 0);

        // R10: short pulse ignored, full pulse restarts
        restart(TCFG - 1, drop);
        chk(drop == 0, "R10 short pulse", drop, 0);
        restart(TCFG, drop);
        chk(drop == TCFG, "R10 restart edge", drop, TCFG);
        chk(done_drive_low && !stat_drive_low && !user_en, "R10 back to load",
            done_drive_low, 1);

        // R11: held request keeps hold phase with status low
        cfg_req_n = 1'b0;
        cyc(TCFG + 5);
        chk(stat_drive_low, "R11 held request", stat_drive_low, 1);
        cfg_req_n = 1'b1;
        #1;
        chk(!stat_drive_low, "R11 release", stat_drive_low, 0);
        cyc(1);

        // R8: automatic recovery
        auto_restart = 1'b1;
        cfg_err = 1'b1;
        cyc(1);
        cfg_err = 1'b0;
        chk(!stat_drive_low, "R8 status released", stat_drive_low, 0);
        load_measure(0, n);
        chk(n == exp_init(0), "R8 load after error", n, exp_init(0));
        restart(TCFG, drop);
        auto_restart = 1'b0;

        // R9: error waits for restart, load ignored
        cfg_err = 1'b1;
        cyc(1);
        cfg_err = 1'b0;
        chk(stat_drive_low && done_drive_low, "R9 status low", stat_drive_low, 1);
        cfg_loaded = 1'b1;
        cyc(1);
        cfg_loaded = 1'b0;
        cyc(70);
        chk(!user_en && stat_drive_low, "R9 load ignored", user_en, 0);
        cfg_req_n = 1'b0;
        cyc(TCFG);
        cfg_req_n = 1'b1;
        #1;
        chk(!stat_drive_low, "R10 restart from error", stat_drive_low, 0);
        cyc(1);

        // R12: error and load together
        cfg_err = 1'b1; cfg_loaded = 1'b1;
        cyc(1);
        cfg_err = 1'b0; cfg_loaded = 1'b0;
        chk(stat_drive_low && done_drive_low, "R12 error over load", stat_drive_low, 1);
        restart(TCFG, drop);
        auto_restart = 1'b1;
        cfg_err = 1'b1; cfg_loaded = 1'b1;
        cyc(1);
        cfg_err = 1'b0; cfg_loaded = 1'b0;
        cyc(70);
        chk(!user_en && !stat_drive_low, "R12 auto error over load", user_en, 0);
        auto_restart = 1'b0;

        // R12: restart beats error on the same edge
        cfg_req_n = 1'b0;
        cyc(TCFG - 1);
        cfg_err = 1'b1;
        cyc(1);
        cfg_err = 1'b0;
        cfg_req_n = 1'b1;
        #1;
        chk(!stat_drive_low, "R12 restart over error", stat_drive_low, 0);
        cyc(1);

        // R3 and R7: short delay, external status pull-down holds the phase
        do_reset();
        stat_ext = 1'b1;
        power_up(2'b01, n);
        chk(n == exp_hold(2'b01), "R3 short delay", n, exp_hold(2'b01));
        cfg_loaded = 1'b1;
        cyc(1);
        cfg_loaded = 1'b0;
        cyc(70);
        chk(!user_en && done_drive_low, "R7 status pulled", user_en, 0);
        stat_ext = 1'b0;
        cyc(1);
        load_measure(0, n);
        chk(n == exp_init(0), "R7 after status free", n, exp_init(0));

        // R4: long delay, both encodings
        do_reset();
        power_up(2'b10, n);
        chk(n == exp_hold(2'b10), "R4 long delay 10", n, exp_hold(2'b10));
        do_reset();
        power_up(2'b11, n);
        chk(n == exp_hold(2'b11), "R4 long delay 11", n, exp_hold(2'b11));

        // R5: power dip restarts the count
        do_reset();
        por_mode = 2'b01;
        pwr_good = 1'b1;
        cyc(30);
        pwr_good = 1'b0;
        cyc(1);
        chk(stat_drive_low, "R5 dip holds status", stat_drive_low, 1);
        power_up(2'b01, n);
        chk(n == exp_hold(2'b01), "R5 count restarted", n, exp_hold(2'b01));

        // R6 R7 R10: random stalls and request lengths
        do_reset();
        power_up(2'b00, n);
        for (int it = 0; it < 12; it++) begin
            int stall;
            int len;
            stall = $urandom_range(0, 20);
            load_measure(stall, n);
            chk(n == exp_init(stall), "R7 random stall", n, exp_init(stall));
            len = $urandom_range(1, TCFG - 1);
            restart(len, drop);
            chk(drop == 0, "R10 random short", drop, 0);
            len = $urandom_range(TCFG, TCFG + 6);
            restart(len, drop);
            chk(drop == TCFG, "R10 random long", drop, TCFG);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule